// File: doc/BRIEF.md
# Framed SPI Sync Pulse Generator

This block sits beside the shift engine of a framed SPI port and owns the single frame pin. As a host it counts serial words and drives a frame sync pulse once per programmed number of words. As an alternative host function it drives a client-select level that follows the transmission-busy flag. As a client it releases the pin, watches for the leading edge of an incoming sync pulse, restarts its word count there and tells the shifter that a frame has begun.

The shift engine provides two single-cycle strobes: one per bit clock and one at the close of each word. The last bit strobe of a word coincides with the word strobe. The period code, pulse width, polarity, direction and select-enable settings come in as static inputs. The pin functions exist only while framed operation is enabled; otherwise the pin is left undriven.

Top module: `frm_sync_gen`

## Requirements
- R1: In host sync mode the pulse repeats every 2^code words for `frm_code_i` values 0 to 5 (1, 2, 4, 8, 16, 32 words). The word counter starts at 0 and advances on each `word_tick_i`, wrapping to 0 after the last word of the period. The pulse occupies word 0.
- R2: The reserved period codes 6 and 7 behave like code 0, one pulse per word.
- R3: With `pw_word_i`=0 the pulse is active from the start of word 0 until the clock edge that samples the first `bit_tick_i` of that word.
- R4: With `pw_word_i`=1 the pulse is active for all of word 0, up to the edge that samples its `word_tick_i`.
- R5: `pol_i`=1 makes the sync pulse and the select active-high on `pin_o`; `pol_i`=0 makes them active-low.
- R6: In host mode (`frm_en_i`=1, `client_i`=0), `pin_oe_o` is 1.
- R7: In client mode (`frm_en_i`=1, `client_i`=1), `pin_oe_o` is 0 and `pin_o` rests at the inactive level. The first clock edge at which `sync_i` is at its active level, after an edge at which it was not, clears the word counter and the bit flag. It also raises `frame_start_o` in the following cycle. `sel_en_i` has no effect in this mode.
- R8: In host mode with `sel_en_i`=1, the pin carries the select instead of the sync pulse: active while `busy_i`=1, inactive otherwise, with no cycle of delay.
- R9: With `frm_en_i`=0, `pin_oe_o` is 0, `pin_o` is at the inactive level, the word counter is held at 0 and no frame start is flagged.
- R10: `frame_start_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_en_i | input | 1 | Framed operation enable |
| client_i | input | 1 | 1 = client (sync input), 0 = host (sync output) |
| sel_en_i | input | 1 | Host auto client-select enable |
| pol_i | input | 1 | 1 = active-high pin, 0 = active-low |
| pw_word_i | input | 1 | 1 = word-wide pulse, 0 = one bit clock wide |
| frm_code_i | input | 3 | Words-per-pulse code |
| bit_tick_i | input | 1 | One-cycle strobe per bit clock |
| word_tick_i | input | 1 | One-cycle strobe at end of word |
| busy_i | input | 1 | Transmission in progress |
| sync_i | input | 1 | Pin input level, synchronous to clk_i |
| pin_o | output | 1 | Pin drive level |
| pin_oe_o | output | 1 | Pin output enable |
| frame_start_o | output | 1 | Frame start to the shifter (client mode) |

## Verification
The properties assume that `sync_i` has already been brought into the clock domain and that `word_tick_i` occurs only together with a `bit_tick_i`. They also assume that settings change only between cycles, never as glitches within one. The stimulus produces the strobes from a bit-phase counter with random idle gaps, so every word strobe lands on the last bit strobe of a four-bit word. Settings are changed on the inactive clock edge only. In the client phases `sync_i` follows a pattern of multi-cycle pulses mixed with single-cycle ones. The mode changes from client back to host happen without dropping framed enable, so the counter reset caused by an incoming edge shows up afterwards in the phase of the host pulse.

// File: rtl/frm_sync_pkg.sv
package frm_sync_pkg;
  typedef enum logic [1:0] {
    PIN_IDLE     = 2'd0,
    PIN_SYNC_OUT = 2'd1,
    PIN_SEL_OUT  = 2'd2,
    PIN_SYNC_IN  = 2'd3
  } pin_role_e;

  function automatic pin_role_e role_of(logic frm_en, logic client, logic sel_en);
    if (!frm_en)     return PIN_IDLE;
    else if (client) return PIN_SYNC_IN;
    else if (sel_en) return PIN_SEL_OUT;
    else             return PIN_SYNC_OUT;
  endfunction
endpackage

// File: rtl/frm_word_ctr.sv
module frm_word_ctr #(
  parameter int CODE_W = 3,
  parameter int MAX_LOG = 5,
  parameter int CNT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              word_tick_i,
  input  logic              bit_tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              no_bit_o
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(MAX_LOG);

  logic [CNT_W-1:0] cnt_q, last;
  logic [CNT_W:0]   span;
  logic             seen_q;

  // reserved codes fold onto one word per frame
  always_comb begin
    span = ({{CNT_W{1'b0}}, 1'b1} << code_i) - 1'b1;
    last = (code_i > MAX_CODE) ? '0 : span[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (!en_i || clr_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (word_tick_i) begin
      cnt_q  <= (cnt_q >= last) ? '0 : cnt_q + 1'b1;
      seen_q <= 1'b0;
    end else if (bit_tick_i) begin
      seen_q <= 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign no_bit_o = ~seen_q;
endmodule

// File: rtl/frm_sync_det.sv
module frm_sync_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pol_i,
  input  logic sync_i,
  output logic edge_o,
  output logic start_o
);
  logic act, prev_q, start_q;

  assign act    = pol_i ? sync_i : ~sync_i;
  assign edge_o = act & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      prev_q  <= act;
      start_q <= en_i & edge_o;
    end
  end

  assign start_o = start_q;
endmodule

// File: rtl/frm_pin_drv.sv
module frm_pin_drv
  import frm_sync_pkg::*;
(
  input  pin_role_e role_i,
  input  logic      pol_i,
  input  logic      pulse_i,
  input  logic      busy_i,
  output logic      pin_o,
  output logic      oe_o
);
  logic lvl;

  always_comb begin
    unique case (role_i)
      PIN_SYNC_OUT: begin lvl = pulse_i; oe_o = 1'b1; end
      PIN_SEL_OUT:  begin lvl = busy_i;  oe_o = 1'b1; end
      default:      begin lvl = 1'b0;    oe_o = 1'b0; end
    endcase
    pin_o = pol_i ? lvl : ~lvl;
  end
endmodule

// File: rtl/frm_sync_gen.sv
module frm_sync_gen
  import frm_sync_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int MAX_LOG = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_en_i,
  input  logic              client_i,
  input  logic              sel_en_i,
  input  logic              pol_i,
  input  logic              pw_word_i,
  input  logic [CODE_W-1:0] frm_code_i,
  input  logic              bit_tick_i,
  input  logic              word_tick_i,
  input  logic              busy_i,
  input  logic              sync_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              frame_start_o
);
  localparam int CNT_W = (MAX_LOG < 1) ? 1 : MAX_LOG;

  pin_role_e        role;
  logic [CNT_W-1:0] cnt_q;
  logic             no_bit, sync_edge, is_client, pulse;

  assign role      = role_of(frm_en_i, client_i, sel_en_i);
  assign is_client = (role == PIN_SYNC_IN);

  frm_word_ctr #(.CODE_W(CODE_W), .MAX_LOG(MAX_LOG), .CNT_W(CNT_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (frm_en_i),
    .clr_i       (is_client & sync_edge),
    .word_tick_i (word_tick_i),
    .bit_tick_i  (bit_tick_i),
    .code_i      (frm_code_i),
    .cnt_o       (cnt_q),
    .no_bit_o    (no_bit)
  );

  frm_sync_det u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (is_client),
    .pol_i   (pol_i),
    .sync_i  (sync_i),
    .edge_o  (sync_edge),
    .start_o (frame_start_o)
  );

  assign pulse = (cnt_q == '0) & (pw_word_i | no_bit);

  frm_pin_drv u_drv (
    .role_i  (role),
    .pol_i   (pol_i),
    .pulse_i (pulse),
    .busy_i  (busy_i),
    .pin_o   (pin_o),
    .oe_o    (pin_oe_o)
  );
endmodule

// File: rtl/frm_sync_gen_chk.sv
module frm_sync_gen_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frm_en_i,
  input logic             client_i,
  input logic             sel_en_i,
  input logic             pol_i,
  input logic             busy_i,
  input logic             word_tick_i,
  input logic             pin_o,
  input logic             pin_oe_o,
  input logic             frame_start_o,
  input logic [CNT_W-1:0] cnt_q
);
  p_cnt_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_en_i && !client_i && !word_tick_i) |=> $stable(cnt_q));

  p_host_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_en_i && !client_i) |-> pin_oe_o);

  p_client_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_en_i && client_i) |-> (!pin_oe_o && pin_o == !pol_i));

  p_start_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> $past(frm_en_i && client_i));

  p_sel_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_en_i && !client_i && sel_en_i) |-> (pin_o == (busy_i ~^ pol_i)));

  p_idle_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_en_i |-> !pin_oe_o);

  p_idle_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_en_i |=> (cnt_q == '0));

  p_start_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);
endmodule

bind frm_sync_gen frm_sync_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frm_en_i      (frm_en_i),
  .client_i      (client_i),
  .sel_en_i      (sel_en_i),
  .pol_i         (pol_i),
  .busy_i        (busy_i),
  .word_tick_i   (word_tick_i),
  .pin_o         (pin_o),
  .pin_oe_o      (pin_oe_o),
  .frame_start_o (frame_start_o),
  .cnt_q         (cnt_q)
);

// File: tb/frm_sync_gen_tb.sv
module frm_sync_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frm_en = 0, client = 0, sel_en = 0, pol = 0, pw_word = 0;
  logic [2:0] code = 3'd0;
  logic bit_tick = 0, word_tick = 0, busy = 0, sync_in = 0;
  logic pin, pin_oe, fstart;

  int vectors = 0, fails = 0;
  string cur_req = "R9";
  bit gen_on = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frm_sync_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frm_en_i(frm_en), .client_i(client),
    .sel_en_i(sel_en), .pol_i(pol), .pw_word_i(pw_word), .frm_code_i(code),
    .bit_tick_i(bit_tick), .word_tick_i(word_tick), .busy_i(busy),
    .sync_i(sync_in), .pin_o(pin), .pin_oe_o(pin_oe), .frame_start_o(fstart)
  );

  // stimulus for strobes, busy and pin input
  bit ph = 0;
  int bidx = 0, tcnt = 0;
  always @(negedge clk) begin
    bit s;
    bit_tick = 0;
    word_tick = 0;
    if (gen_on && $urandom_range(7) != 0) begin
      ph = !ph;
      if (ph) begin
        bit_tick = 1;
        if (bidx == WL-1) begin word_tick = 1; bidx = 0; end
        else bidx++;
      end
    end
    tcnt++;
    if (client) s = ((tcnt % 29) < 3) || ((tcnt % 41) == 0);
    else        s = ($urandom_range(1) == 1);
    sync_in = pol ? s : !s;
    if ($urandom_range(9) == 0) busy = !busy;
  end

  // behavioural reference
  int m_cnt = 0;
  bit m_seen = 0, m_prev = 0, m_fs = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_seen = 0; m_prev = 0; m_fs = 0;
    end else begin
      bit act, rise;
      int per;
      act  = pol ? sync_in : !sync_in;
      rise = act && !m_prev;
      per  = (code <= 5) ? (1 << code) : 1;
      m_fs = frm_en && client && rise;
      if (!frm_en || (client && rise)) begin
        m_cnt = 0; m_seen = 0;
      end else if (word_tick) begin
        m_cnt  = (m_cnt >= per - 1) ? 0 : m_cnt + 1;
        m_seen = 0;
      end else if (bit_tick) m_seen = 1;
      m_prev = act;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit e_pin, e_oe, lvl;
      if (!frm_en || client) begin e_oe = 0; lvl = 0; end
      else if (sel_en)       begin e_oe = 1; lvl = busy; end
      else begin
        e_oe = 1;
        lvl  = (m_cnt == 0) && (pw_word || !m_seen);
      end
      e_pin = pol ? lvl : !lvl;
      vectors++;
      if (pin !== e_pin || pin_oe !== e_oe || fstart !== m_fs) begin
        fails++;
        $display("FAIL %s t=%0t pin/oe/fs=%b%b%b expected %b%b%b",
                 cur_req, $time, pin, pin_oe, fstart, e_pin, e_oe, m_fs);
      end
    end
  end

  task automatic cfg(input bit en, input bit cl, input bit se, input bit p,
                     input bit pw, input logic [2:0] c, input string tag, input int n);
    @(negedge clk);
    frm_en = en; client = cl; sel_en = se; pol = p; pw_word = pw; code = c;
    cur_req = tag;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R9
    vectors++;
    if (pin_oe !== 0 || fstart !== 0) begin
      fails++;
      $display("FAIL R9 reset oe/fs=%b%b expected 00", pin_oe, fstart);
    end
    rst_n = 1;
    gen_on = 1;
    cfg(0, 0, 0, 0, 0, 3'd0, "R9", 60);
    // host periods, widths, polarities (R1 R2 R3 R4 R5 R6)
    for (int c = 0; c < 8; c++)
      for (int pw = 0; pw < 2; pw++)
        for (int p = 0; p < 2; p++)
          cfg(1, 0, 0, p[0], pw[0], c[2:0],
              {(c > 5) ? "R2" : "R1", pw ? "/R4" : "/R3", "/R5/R6"}, 700);
    // select line (R8)
    cfg(1, 0, 1, 0, 0, 3'd2, "R8", 400);
    cfg(1, 0, 1, 1, 1, 3'd3, "R8", 400);
    // client edges, counter restart, select ignored (R7 R10)
    cfg(1, 1, 0, 1, 0, 3'd2, "R7/R10", 800);
    cfg(1, 0, 0, 1, 0, 3'd2, "R7", 300);
    cfg(1, 1, 1, 0, 1, 3'd3, "R7/R10", 800);
    cfg(1, 0, 0, 0, 1, 3'd3, "R7", 400);
    cfg(1, 1, 0, 0, 0, 3'd4, "R7/R10", 600);
    // disable clears and releases (R9)
    cfg(0, 1, 0, 1, 0, 3'd1, "R9", 200);
    cfg(1, 0, 0, 1, 0, 3'd1, "R9", 200);
    cfg(0, 0, 1, 0, 0, 3'd1, "R9", 200);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    done = 1;
    fails++;
    $display("FAIL watchdog expired, stimulus did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule